// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor

This block is a combinational two's-complement adder/subtractor. One mode input selects the operation. It forms either the sum or the difference of two unsigned operands in a single evaluation, with no clock. It also returns a carry-out. In add mode the carry-out is the ninth bit of the sum. In subtract mode it is the inverse of the borrow.

The operand width is cut into equal segments. The lowest segment is a ripple-carry chain of full-adder cells, and its carry-in is the mode bit. Every higher segment is built twice, side by side. One copy assumes an incoming carry of 0 and the other assumes 1. The true carry from the segment below then picks one copy through a multiplexer. The second operand passes through an XOR stage driven by the mode before it reaches any segment. In subtract mode the unit therefore computes A + ~B + 1. At the default parameters there are 8 bits in two 4-bit segments, which makes three 4-bit ripple adders in all.

A datapath uses the block wherever it needs an add-or-subtract step with a sign or borrow flag. One example is the partial-remainder update of a non-restoring divider.

Top module: `csel_addsub`

## Requirements
- R1: With `sub_mode`=0, `result` equals (`opa`+`opb`) mod 2^WIDTH.
- R2: With `sub_mode`=0, `carry_out` equals bit WIDTH of the full sum `opa`+`opb`.
- R3: With `sub_mode`=1, `result` equals (`opa`-`opb`) mod 2^WIDTH.
- R4: With `sub_mode`=1, `carry_out` is 1 exactly when `opa` >= `opb` as unsigned numbers (no borrow).
- R5: `result[SEG-1:0]` depends only on `opa[SEG-1:0]`, `opb[SEG-1:0]` and `sub_mode`. It equals their low-segment sum or difference modulo 2^SEG.
- R6: Let k be the upper segment's low bit and c the carry out of the segment below, where that segment's carry-in is `sub_mode`. Then `result[WIDTH-1:k]` equals `opa[WIDTH-1:k]` + (`opb[WIDTH-1:k]` XOR `sub_mode`) + c, modulo the segment size.
- R7: The block holds no state. Its outputs follow any change of the inputs without a clock edge, and with all inputs at zero it outputs `result`=0 and `carry_out`=0.
- R8: Subtracting zero returns `opa` with `carry_out`=1. Subtracting any nonzero `opb` from zero returns 2^WIDTH-`opb` with `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (8) | First operand (minuend in subtract mode) |
| opb | input | WIDTH (8) | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH (8) | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit; in subtract mode 1 means no borrow |

## Verification
A table of hand-chosen vectors targets carry movement through the design. It includes nibble-boundary carries such as 0x0F+0x01 and borrows such as 0x10-0x01, which separate a correct segment select from a wrong one. It also includes full-width wraparound such as 0xFF+0x01, which exercises the carry-out, and equal-operand and zero-operand subtraction, which pin down the borrow sense. The bench then sweeps every operand pair in both modes. That sweep separates faults that only particular bit patterns reveal, such as a swapped multiplexer leg or a missing inversion on one speculative copy. Directed checks then compare the low segment and the upper segment against independently computed segment arithmetic. Finally, a change of inputs between clock edges shows that the outputs follow with no register in the path.

// File: rtl/csel_pkg.sv
package csel_pkg;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } csel_op_e;

endpackage

// File: rtl/csel_fa.sv
module csel_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);

   logic p;

   assign p  = a ^ b;
   assign s  = p ^ ci;
   assign co = (a & b) | (p & ci);

endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   if (W < 1) begin : g_bad_width
      $error("csel_ripple: W must be at least 1");
   end

   logic [W:0] c;

   assign c[0] = ci;

   for (genvar i = 0; i < W; i++) begin : g_cell
      csel_fa u_fa (
         .a  (a[i]),
         .b  (b[i]),
         .ci (c[i]),
         .s  (s[i]),
         .co (c[i+1])
      );
   end

   assign co = c[W];

endmodule

// File: rtl/csel_cond.sv
module csel_cond #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   input  logic         inv,
   output logic [W-1:0] dout
);

   for (genvar i = 0; i < W; i++) begin : g_xor
      assign dout[i] = din[i] ^ inv;
   end

endmodule

// File: rtl/csel_addsub.sv
module csel_addsub
   import csel_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned SEG   = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int unsigned NSEG = WIDTH / SEG;

   if (SEG < 1) begin : g_bad_seg
      $error("csel_addsub: SEG must be at least 1");
   end
   if (WIDTH % SEG != 0) begin : g_bad_split
      $error("csel_addsub: WIDTH must be a multiple of SEG");
   end
   if (NSEG < 2) begin : g_bad_count
      $error("csel_addsub: at least two segments are required");
   end

   csel_op_e         op;
   logic             inv;
   logic [WIDTH-1:0] opb_c;
   logic [NSEG:0]    seg_carry;

   assign op  = csel_op_e'(sub_mode);
   assign inv = (op == OP_SUB);

   csel_cond #(.W(WIDTH)) u_cond (
      .din  (opb),
      .inv  (inv),
      .dout (opb_c)
   );

   assign seg_carry[0] = inv;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int unsigned LO = s * SEG;

      if (s == 0) begin : g_base
         logic [SEG-1:0] sum_w;
         logic           co_w;

         csel_ripple #(.W(SEG)) u_rip (
            .a  (opa[LO +: SEG]),
            .b  (opb_c[LO +: SEG]),
            .ci (seg_carry[0]),
            .s  (sum_w),
            .co (co_w)
         );

         assign result[LO +: SEG] = sum_w;
         assign seg_carry[1]      = co_w;
      end else begin : g_spec
         logic [SEG-1:0] sum0, sum1;
         logic           co0, co1;

         csel_ripple #(.W(SEG)) u_rip0 (
            .a  (opa[LO +: SEG]),
            .b  (opb_c[LO +: SEG]),
            .ci (1'b0),
            .s  (sum0),
            .co (co0)
         );

         csel_ripple #(.W(SEG)) u_rip1 (
            .a  (opa[LO +: SEG]),
            .b  (opb_c[LO +: SEG]),
            .ci (1'b1),
            .s  (sum1),
            .co (co1)
         );

         assign result[LO +: SEG] = seg_carry[s] ? sum1 : sum0;
         assign seg_carry[s+1]    = seg_carry[s] ? co1  : co0;
      end
   end

   assign carry_out = seg_carry[NSEG];

endmodule

// File: rtl/csel_addsub_chk.sv
module csel_addsub_chk #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned SEG   = 4
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             sub_mode,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             low_carry
);

   localparam int unsigned HI = WIDTH - SEG;

   logic [WIDTH:0] full_add;
   logic [WIDTH:0] full_sub;
   logic [SEG:0]   low_ref;
   logic [HI-1:0]  hi_ref;

   always_comb begin
      full_add = {1'b0, opa} + {1'b0, opb};
      full_sub = {1'b0, opa} - {1'b0, opb};
      low_ref  = {1'b0, opa[SEG-1:0]} + {1'b0, opb[SEG-1:0] ^ {SEG{sub_mode}}}
                 + {{SEG{1'b0}}, sub_mode};
      hi_ref   = opa[WIDTH-1:SEG] + (opb[WIDTH-1:SEG] ^ {HI{sub_mode}})
                 + {{(HI-1){1'b0}}, low_carry};

      if (!$isunknown({opa, opb, sub_mode})) begin
         if (!sub_mode) begin
            p_sum_r1: assert (result == full_add[WIDTH-1:0])
               else $error("R1: sum mismatch");
            p_carry_r2: assert (carry_out == full_add[WIDTH])
               else $error("R2: carry mismatch");
         end else begin
            p_diff_r3: assert (result == full_sub[WIDTH-1:0])
               else $error("R3: difference mismatch");
            p_noborrow_r4: assert (carry_out == (opa >= opb))
               else $error("R4: borrow sense mismatch");
         end
         p_low_seg_r5: assert (result[SEG-1:0] == low_ref[SEG-1:0])
            else $error("R5: low segment mismatch");
         p_low_carry_r6: assert (low_carry == low_ref[SEG])
            else $error("R6: low segment carry mismatch");
         p_hi_select_r6: assert (result[WIDTH-1:SEG] == hi_ref)
            else $error("R6: upper segment select mismatch");
      end
   end

endmodule

bind csel_addsub csel_addsub_chk #(
   .WIDTH (WIDTH),
   .SEG   (SEG)
) u_chk (
   .opa       (opa),
   .opb       (opb),
   .sub_mode  (sub_mode),
   .result    (result),
   .carry_out (carry_out),
   .low_carry (seg_carry[1])
);

// File: tb/csel_addsub_bench.sv
`timescale 1ns/1ps
module csel_addsub_bench;

   logic       clk = 1'b0;
   logic [7:0] opa = 8'h00;
   logic [7:0] opb = 8'h00;
   logic       sub_mode = 1'b0;
   logic [7:0] result;
   logic       carry_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   csel_addsub u_csel_addsub (
      .opa       (opa),
      .opb       (opb),
      .sub_mode  (sub_mode),
      .result    (result),
      .carry_out (carry_out)
   );

   // {a, b, mode, expected result, expected carry}
   localparam int NVEC = 14;
   localparam logic [25:0] VEC [NVEC] = '{
      {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},  // R1 zero
      {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},  // R2 full wrap
      {8'h0F, 8'h01, 1'b0, 8'h10, 1'b0},  // R6 nibble carry
      {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},  // R2 top carry only
      {8'h5A, 8'hA5, 1'b0, 8'hFF, 1'b0},  // R1 no carries
      {8'h37, 8'h49, 1'b0, 8'h80, 1'b0},  // R6 carry into upper
      {8'h0F, 8'h0F, 1'b0, 8'h1E, 1'b0},  // R1
      {8'h05, 8'h05, 1'b1, 8'h00, 1'b1},  // R4 equal
      {8'h00, 8'h01, 1'b1, 8'hFF, 1'b0},  // R8 zero minus one
      {8'h10, 8'h01, 1'b1, 8'h0F, 1'b1},  // R6 borrow across nibble
      {8'h7F, 8'h80, 1'b1, 8'hFF, 1'b0},  // R4 just below
      {8'hFF, 8'h00, 1'b1, 8'hFF, 1'b1},  // R8 minus zero
      {8'h00, 8'h00, 1'b1, 8'h00, 1'b1},  // R8 zero minus zero
      {8'hC8, 8'h64, 1'b1, 8'h64, 1'b1}   // R3
   };

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: a=%02h b=%02h mode=%0d actual=%03h expected=%03h",
                  tag, opa, opb, sub_mode, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic m);
      opa = a;
      opb = b;
      sub_mode = m;
      #1;
   endtask

   initial begin : main
      logic [8:0] exp;
      logic [4:0] lo;
      logic [3:0] hi;

      // R7: idle inputs at zero give zero outputs
      #1;
      chk("R7 reset", {carry_out, result}, 9'h000);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
         chk(VEC[i][9] ? "R3/R4 table" : "R1/R2 table",
             {carry_out, result}, {VEC[i][0], VEC[i][8:1]});
         #1;
      end

      // R7: output follows input between clock edges
      @(posedge clk);
      #0.5;
      apply(8'h21, 8'h12, 1'b0);
      chk("R7 no clock", {carry_out, result}, 9'h033);
      apply(8'h21, 8'h12, 1'b1);
      chk("R7 no clock", {carry_out, result}, 9'h10F);

      // R5 and R6: segment arithmetic on chosen patterns
      for (int k = 0; k < 16; k++) begin
         logic [7:0] a = 8'(k * 17 + 3);
         logic [7:0] b = 8'(k * 29 + 11);
         for (int m = 0; m < 2; m++) begin
            apply(a, b, m[0]);
            lo  = {1'b0, a[3:0]} + {1'b0, b[3:0] ^ {4{m[0]}}} + {4'd0, m[0]};
            hi  = a[7:4] + (b[7:4] ^ {4{m[0]}}) + {3'd0, lo[4]};
            chk("R5 low", {5'd0, result[3:0]}, {5'd0, lo[3:0]});
            chk("R6 high", {5'd0, result[7:4]}, {5'd0, hi});
            #1;
         end
      end

      // R8: subtract zero / from zero
      for (int v = 1; v < 256; v += 37) begin
         apply(8'(v), 8'h00, 1'b1);
         chk("R8 minus zero", {carry_out, result}, {1'b1, 8'(v)});
         apply(8'h00, 8'(v), 1'b1);
         chk("R8 from zero", {carry_out, result}, {1'b0, 8'(256 - v)});
      end

      // exhaustive sweep, both modes
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            for (int m = 0; m < 2; m++) begin
               apply(8'(a), 8'(b), m[0]);
               if (m == 0) begin
                  exp = 9'(a + b);
                  chk("R1/R2 sweep", {carry_out, result}, exp);
               end else begin
                  exp = {(a >= b) ? 1'b1 : 1'b0, 8'(a - b)};
                  chk("R3/R4 sweep", {carry_out, result}, exp);
               end
               #1;
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule